// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It takes words from the read side of a transmit FIFO and shifts them out on MOSI, most significant bit first. At the same time it samples MISO and writes each received word into the write side of a receive FIFO. The FIFOs, the interrupt logic and the register decoding all sit outside the block. The block sees only the FIFO handshake: an empty flag with first-word-fall-through data on the transmit side, and a one-cycle write strobe on the receive side.

Software programs several settings through plain configuration inputs:

- clock polarity and clock phase, as separate bits;
- a frame size code that selects 4, 8 or 16 bits;
- a 16-bit baud divider;
- an enable bit;
- a two-bit chip-select mask.

Polarity, phase, frame size and divider are captured only while the engine is disabled. Reprogramming therefore means clearing enable, changing the settings and enabling again. The chip-select mask is applied live, so software can hold a device selected across several frames. A registered busy flag tells software when the engine has finished.

Top module: `spi_shift_master`

## Requirements
- R1: While reset is held and right after it: both chip selects high, SCLK low, busy low, and no FIFO pop or push.
- R2: A frame starts only when enable is 1, at least one chip-select bit is 1 and the transmit FIFO is not empty. Each frame pulses txf_pop for exactly one cycle.
- R3: Frame size code 0 sends 4 bits, code 1 sends 8 bits, and codes 2 and 3 send 16 bits. The low bits of the FIFO word are sent, MSB first.
- R4: Every completed frame pulses rxf_push once. The received bits sit right-aligned in rxf_wr_data, with the unused upper bits at zero.
- R5: With phase 0, MISO is sampled on the leading SCLK edge and MOSI changes on the trailing edge. With phase 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Mode 0 sets neither bit, mode 1 sets phase, mode 2 sets polarity and mode 3 sets both.
- R6: Whenever no frame is running, SCLK rests at the polarity level.
- R7: Each SCLK half period lasts floor(divider/2) input clocks. Bit 0 of the divider is ignored, and a divider below 2 acts as 2 (one clock per half period).
- R8: One cycle after the inputs, cs_n[i] is low exactly when enable is 1 and select bit i is 1. Both chip selects are high while the engine is disabled.
- R9: Polarity, phase, frame size and divider are captured only on cycles where enable is 0. Changes made while enabled have no effect.
- R10: Clearing enable stops a frame in progress. No word is pushed for it, and SCLK returns to the polarity level.
- R11: busy is high from the start of a frame until its end, and also while the engine is enabled with transmit data waiting. It is low when idle with an empty FIFO or when disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_cpol | input | 1 | Clock polarity (idle SCLK level) |
| cfg_cpha | input | 1 | Clock phase |
| cfg_frame_size | input | 2 | Frame size code: 0=4, 1=8, 2 or 3=16 bits |
| cfg_baud_div | input | 16 | SCLK divider |
| cfg_slave_sel | input | 2 | Chip-select mask, 1 selects |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_rd_data | input | 16 | Transmit FIFO head word |
| txf_pop | output | 1 | Transmit FIFO read strobe |
| rxf_push | output | 1 | Receive FIFO write strobe |
| rxf_wr_data | output | 16 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |
| busy | output | 1 | Engine busy |

## Verification
The assertions run on every cycle and check the following:

- the single-cycle pop and the conditions that allow a frame to start;
- that pushes occur only while the engine is enabled and busy;
- that chip selects are released after a disable;
- the resting SCLK level;
- that the half-period counter stays bounded.

Bit order, frame width, the sampling edge in each of the four modes, exact half-period lengths, the ignoring of configuration changes while enabled, and the abort path can only be shown by the bench scenarios. These scenarios use a behavioural slave and a reference model that is compared on every clock.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  localparam int PKG_WORD_W = 16;
  localparam int PKG_DIV_W  = 16;
  localparam int PKG_NUM_CS = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } eng_state_t;

  // Frame size code to bit count; codes 2 and 3 both give 16 bits.
  function automatic int unsigned frame_bits(input logic [1:0] code);
    case (code)
      2'd0:    frame_bits = 4;
      2'd1:    frame_bits = 8;
      default: frame_bits = 16;
    endcase
  endfunction

endpackage

// File: rtl/spi_baud_tick.sv
module spi_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_q;

  // Half period in input clocks; bit 0 is dropped and the minimum is one.
  always_comb begin
    if (div < DIV_W'(2)) half = ONE;
    else                 half = div >> 1;
  end

  assign tick = run && (cnt_q == half - ONE);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + ONE;
  end

  AST_TICK_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt_q < half); // R7

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter import spi_shift_pkg::*; #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [1:0]        size_code,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              miso,
  output logic              mosi_bit,
  output logic [WORD_W-1:0] rx_word
);

  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] rx_next;

  // Per-bit mask, one lane per bit position.
  for (genvar b = 0; b < WORD_W; b++) begin : g_mask
    assign mask[b] = (b < int'(frame_bits(size_code)));
  end

  assign rx_next  = {rx_q[WORD_W-2:0], miso};
  assign mosi_bit = tx_q[WORD_W-1];
  // Word including a sample taken on this very edge, cut to the frame width.
  assign rx_word  = (sample_en ? rx_next : rx_q) & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= load_word << (WORD_W - int'(frame_bits(size_code)));
      rx_q <= '0;
    end else begin
      if (shift_en)  tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      if (sample_en) rx_q <= rx_next;
    end
  end

  AST_NO_LOAD_MID_EDGE: assert property (@(posedge clk) disable iff (rst)
    load |-> !(shift_en || sample_en)); // R2

endmodule

// File: rtl/spi_cfg_latch.sv
module spi_cfg_latch #(
  parameter int DIV_W  = 16,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [1:0]        size,
  input  logic [DIV_W-1:0]  div,
  input  logic [NUM_CS-1:0] sel,
  output logic              sh_cpol,
  output logic              sh_cpha,
  output logic [1:0]        sh_size,
  output logic [DIV_W-1:0]  sh_div,
  output logic [NUM_CS-1:0] cs_n
);

  logic [NUM_CS-1:0] cs_n_d;

  // Link settings follow the inputs only while the engine is off.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cpol <= 1'b0;
      sh_cpha <= 1'b0;
      sh_size <= 2'd1;
      sh_div  <= DIV_W'(2);
    end else if (!enable) begin
      sh_cpol <= cpol;
      sh_cpha <= cpha;
      sh_size <= size;
      sh_div  <= div;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n_d[i] = !(enable && sel[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) cs_n <= '1;
    else     cs_n <= cs_n_d;
  end

  AST_CS_RELEASED_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> cs_n == '1); // R8

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master import spi_shift_pkg::*; #(
  parameter int WORD_W = PKG_WORD_W,
  parameter int DIV_W  = PKG_DIV_W,
  parameter int NUM_CS = PKG_NUM_CS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [1:0]        cfg_frame_size,
  input  logic [DIV_W-1:0]  cfg_baud_div,
  input  logic [NUM_CS-1:0] cfg_slave_sel,
  input  logic              txf_empty,
  input  logic [WORD_W-1:0] txf_rd_data,
  output logic              txf_pop,
  output logic              rxf_push,
  output logic [WORD_W-1:0] rxf_wr_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              busy
);

  localparam int ECNT_W = $clog2(2 * WORD_W);

  eng_state_t        st_q, st_n;
  logic [ECNT_W-1:0] ecnt_q;
  logic              sh_cpol, sh_cpha;
  logic [1:0]        sh_size;
  logic [DIV_W-1:0]  sh_div;
  logic              run, tick, edge_tick, last_edge, start;
  logic              sample_en, shift_en;
  logic [WORD_W-1:0] rx_word;
  logic              sclk_q, pop_q, push_q, busy_q;
  logic [WORD_W-1:0] rx_data_q;

  spi_cfg_latch #(.DIV_W(DIV_W), .NUM_CS(NUM_CS)) i_cfg (
    .clk(clk), .rst(rst), .enable(cfg_enable),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .size(cfg_frame_size), .div(cfg_baud_div),
    .sel(cfg_slave_sel),
    .sh_cpol(sh_cpol), .sh_cpha(sh_cpha), .sh_size(sh_size), .sh_div(sh_div),
    .cs_n(cs_n)
  );

  assign run = (st_q != ST_IDLE);

  spi_baud_tick #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst(rst), .run(run), .div(sh_div), .tick(tick)
  );

  assign start     = (st_q == ST_IDLE) && cfg_enable && (|cfg_slave_sel) && !txf_empty;
  assign edge_tick = (st_q == ST_RUN) && tick;
  assign last_edge = (ecnt_q == ECNT_W'(2 * frame_bits(sh_size) - 1));
  // Edge parity against the phase bit picks sample or shift edges.
  assign sample_en = edge_tick && (ecnt_q[0] == sh_cpha);
  assign shift_en  = edge_tick && (ecnt_q[0] != sh_cpha) && (ecnt_q != '0);

  spi_frame_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst(rst), .load(start), .load_word(txf_rd_data),
    .size_code(sh_size), .shift_en(shift_en), .sample_en(sample_en),
    .miso(miso), .mosi_bit(mosi), .rx_word(rx_word)
  );

  always_comb begin
    st_n = st_q;
    if (!cfg_enable) begin
      st_n = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (start) st_n = ST_RUN;
        ST_RUN:  if (edge_tick && last_edge) st_n = ST_TAIL;
        ST_TAIL: if (tick) st_n = ST_IDLE;
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ecnt_q    <= '0;
      sclk_q    <= 1'b0;
      pop_q     <= 1'b0;
      push_q    <= 1'b0;
      rx_data_q <= '0;
      busy_q    <= 1'b0;
    end else begin
      st_q   <= st_n;
      pop_q  <= start;
      push_q <= edge_tick && last_edge && cfg_enable;
      busy_q <= (st_n != ST_IDLE) || (cfg_enable && !txf_empty);
      if (edge_tick && last_edge) rx_data_q <= rx_word;
      if (st_n != ST_RUN)  ecnt_q <= '0;
      else if (edge_tick)  ecnt_q <= ecnt_q + ECNT_W'(1);
      if ((st_q != ST_RUN) || !cfg_enable) sclk_q <= sh_cpol;
      else if (edge_tick)                  sclk_q <= ~sclk_q;
    end
  end

  assign txf_pop     = pop_q;
  assign rxf_push    = push_q;
  assign rxf_wr_data = rx_data_q;
  assign sclk        = sclk_q;
  assign busy        = busy_q;

  AST_POP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    txf_pop |=> !txf_pop); // R2
  AST_POP_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
    txf_pop |-> $past(!txf_empty && cfg_enable && (|cfg_slave_sel))); // R2
  AST_PUSH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    rxf_push |-> $past(cfg_enable)); // R10
  AST_PUSH_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rxf_push |-> busy); // R11
  AST_IDLE_SCLK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && $past(st_q == ST_IDLE) && $stable(sh_cpol)) |-> sclk == sh_cpol); // R6

endmodule

// File: tb/test_spi_shift_master.sv
module test_spi_shift_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic        cfg_cpol = 1'b0;
  logic        cfg_cpha = 1'b0;
  logic [1:0]  cfg_frame_size = 2'd1;
  logic [15:0] cfg_baud_div = 16'd2;
  logic [1:0]  cfg_slave_sel = 2'b00;
  logic        txf_empty = 1'b1;
  logic [15:0] txf_rd_data = 16'h0;
  logic        txf_pop, rxf_push, sclk, mosi, busy;
  logic        miso = 1'b0;
  logic [15:0] rxf_wr_data;
  logic [1:0]  cs_n;

  always #5 clk = ~clk;

  spi_shift_master i_spi_shift_master (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_frame_size(cfg_frame_size), .cfg_baud_div(cfg_baud_div),
    .cfg_slave_sel(cfg_slave_sel), .txf_empty(txf_empty), .txf_rd_data(txf_rd_data),
    .txf_pop(txf_pop), .rxf_push(rxf_push), .rxf_wr_data(rxf_wr_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy)
  );

  int total = 0, bad = 0;
  int pops = 0, pushes = 0, exp_pushes = 0, cyc = 0;
  logic [15:0] txq[$];
  logic [15:0] swq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic int nbits(input logic [1:0] c);
    return (c == 2'd0) ? 4 : (c == 2'd1) ? 8 : 16;
  endfunction

  function automatic logic [15:0] msk(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  // Reference model state, captured at rising edges.
  logic [1:0]  exp_cs = 2'b11;
  logic        m_cpol = 1'b0, m_cpha = 1'b0, m_cpol_d = 1'b0, m_en = 1'b0;
  logic [1:0]  m_size = 2'd1;
  logic [15:0] m_div = 16'd2;

  always @(posedge clk) begin
    exp_cs   <= rst ? 2'b11 : ~(cfg_slave_sel & {2{cfg_enable}});
    m_cpol_d <= m_cpol;
    m_en     <= cfg_enable && !rst;
    if (rst) begin
      m_cpol <= 1'b0; m_cpha <= 1'b0; m_size <= 2'd1; m_div <= 16'd2;
    end else if (!cfg_enable) begin
      m_cpol <= cfg_cpol; m_cpha <= cfg_cpha; m_size <= cfg_frame_size; m_div <= cfg_baud_div;
    end
  end

  // Behavioural slave plus per-cycle comparison, away from the active edge.
  logic [15:0] cur_tx = 0, cur_sw = 0, sw = 0, slave_rx = 0;
  logic        prev_sclk = 1'b0, prev_busy = 1'b0, prev_pop = 1'b0, in_frame = 1'b0;
  int          last_tog = 0;

  always @(negedge clk) begin
    int half_m, n_m;
    bit lead, samp;
    cyc++;
    if (cyc > 150000) begin
      chk(0, "WATCHDOG", "run did not finish", cyc, 150000);
      finish_up();
    end
    n_m    = nbits(m_size);
    half_m = (m_div < 16'd2) ? 1 : int'(m_div >> 1);
    if (!rst) begin
      chk(cs_n == exp_cs, "R8", "cs_n", cs_n, exp_cs);
      if (!m_en) in_frame = 1'b0;
      if (txf_pop) begin
        chk(!prev_pop, "R2", "pop longer than one cycle", 1, 0);
        pops++;
        if (txq.size() > 0) begin cur_tx = txq.pop_front(); cur_sw = swq.pop_front(); end
        sw       = cur_sw << (16 - n_m);
        slave_rx = 16'h0;
        last_tog = cyc;
        in_frame = 1'b1;
      end
      if (sclk != prev_sclk && in_frame) begin
        chk(cyc - last_tog == half_m, "R7", "half period", cyc - last_tog, half_m);
        last_tog = cyc;
        lead = (prev_sclk == m_cpol);
        samp = m_cpha ? !lead : lead;  // R5 sampling edge
        if (samp) begin
          slave_rx = {slave_rx[14:0], mosi};
          sw       = sw << 1;
        end
      end
      if (rxf_push) begin
        pushes++;
        chk(rxf_wr_data == (cur_sw & msk(n_m)), "R4", "received word",
            rxf_wr_data, cur_sw & msk(n_m));
        chk(slave_rx == (cur_tx & msk(n_m)), "R3", "bits seen by slave",
            slave_rx, cur_tx & msk(n_m));
        in_frame = 1'b0;
      end
      if (!busy && !prev_busy)
        chk(sclk == m_cpol_d, "R6", "idle sclk", sclk, m_cpol_d);
    end
    miso      = sw[15];
    prev_sclk = sclk;
    prev_busy = busy;
    prev_pop  = txf_pop;
    txf_empty   = (txq.size() == 0);
    txf_rd_data = (txq.size() == 0) ? 16'h0 : txq[0];
  end

  task automatic setup(input logic p, input logic h, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_enable = 1'b0;
    cfg_cpol = p; cfg_cpha = h; cfg_frame_size = s; cfg_baud_div = d;
    @(negedge clk);
  endtask

  task automatic put(input logic [15:0] tx, input logic [15:0] rx);
    txq.push_back(tx);
    swq.push_back(rx);
    exp_pushes++;
  endtask

  task automatic go(input logic [1:0] sel);
    @(negedge clk);
    cfg_enable = 1'b1;
    cfg_slave_sel = sel;
  endtask

  task automatic wait_pushes(input int n);
    int t = 0;
    while (pushes < n && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic settle(input string req);
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(pushes == exp_pushes, "R4", "push count", pushes, exp_pushes);
    chk(pops == pushes, "R2", "pop count", pops, pushes);
    chk(busy == 1'b0, req, "busy after drain", busy, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n == 2'b11, "R1", "cs_n in reset", cs_n, 2'b11);
    chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(!txf_pop && !rxf_push, "R1", "strobes in reset", {txf_pop, rxf_push}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 2'b11 && !busy, "R1", "state after reset", {cs_n, busy}, 3'b110);

    // Mode 0, 8-bit frames, divider 4, back to back.
    setup(1'b0, 1'b0, 2'd1, 16'd4);
    put(16'h00A5, 16'h005A);
    put(16'h013C, 16'h00C3);
    go(2'b01);
    while (pops < 1) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R11", "busy mid frame", busy, 1);
    wait_pushes(exp_pushes);
    settle("R11");

    // Mode 3, 16-bit frames, divider 6.
    setup(1'b1, 1'b1, 2'd2, 16'd6);
    put(16'hBEEF, 16'h1234);
    put(16'h8001, 16'hFFFE);
    go(2'b10);
    wait_pushes(exp_pushes);
    settle("R5");

    // Mode 1, 4-bit frames, divider 1 acts as 2.
    setup(1'b0, 1'b1, 2'd0, 16'd1);
    put(16'h00F9, 16'h00A6);
    put(16'h0003, 16'h000C);
    go(2'b01);
    wait_pushes(exp_pushes);
    settle("R7");

    // Mode 2, 8-bit frames, odd divider 7 gives half period 3.
    setup(1'b1, 1'b0, 2'd1, 16'd7);
    put(16'h0081, 16'h007E);
    go(2'b11);
    wait_pushes(exp_pushes);
    settle("R5");

    // Size code 3 sends 16 bits.
    setup(1'b0, 1'b0, 2'd3, 16'd2);
    put(16'hC0DE, 16'h55AA);
    go(2'b01);
    wait_pushes(exp_pushes);
    settle("R3");

    // No slave selected: data waits, busy high, chip selects idle.
    setup(1'b0, 1'b1, 2'd1, 16'd2);
    put(16'h0042, 16'h0024);
    go(2'b00);
    repeat (40) @(negedge clk);
    chk(pops == pushes, "R2", "no start without select", pops, pushes);
    chk(busy == 1'b1, "R11", "busy with pending data", busy, 1);
    chk(cs_n == 2'b11, "R8", "cs_n with empty mask", cs_n, 2'b11);
    cfg_slave_sel = 2'b10;
    @(negedge clk);
    chk(cs_n == 2'b01, "R8", "cs_n follows mask", cs_n, 2'b01);
    wait_pushes(exp_pushes);
    settle("R2");

    // Settings changed while enabled are ignored.
    setup(1'b0, 1'b0, 2'd1, 16'd4);
    go(2'b01);
    @(negedge clk);
    cfg_cpol = 1'b1; cfg_baud_div = 16'd20; cfg_frame_size = 2'd2;
    repeat (10) @(negedge clk);
    chk(sclk == 1'b0, "R9", "polarity change while enabled", sclk, 0);
    put(16'h0033, 16'h00CC);
    wait_pushes(exp_pushes);
    settle("R9");

    // Disable in the middle of a frame.
    setup(1'b1, 1'b1, 2'd2, 16'd40);
    put(16'hF00D, 16'h0FF0);
    exp_pushes--;
    go(2'b01);
    while (pops == pushes) @(negedge clk);
    repeat (50) @(negedge clk);
    cfg_enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b1, "R10", "sclk after abort", sclk, 1);
    chk(busy == 1'b0, "R10", "busy after abort", busy, 0);
    repeat (700) @(negedge clk);
    chk(pushes == exp_pushes, "R10", "no push for aborted frame", pushes, exp_pushes);
    chk(cs_n == 2'b11, "R8", "cs_n while disabled", cs_n, 2'b11);

    finish_up();
  end

endmodule